// File: doc/BRIEF.md
# Banked-Mode Exception Entry Unit

This unit performs the register-bank side of taking an exception on a 32-bit core. The core has six privilege modes. Five storage banks hold private copies of two general registers (r29 and r30) and of a saved-status word. The two user-level modes share one bank. The core presents one or more exception requests together with its live status word, PC, r29, r30 and saved-status values, and a control bit that moves the vector table high. The unit accepts the request through a valid/ack handshake and parks the outgoing mode's registers in that mode's bank. It then restores the incoming mode's bank onto its register outputs. Finally it commits the new status word, the return address and the vector PC, and marks the commit with a one-cycle `done` pulse.

Mode codes live in bits [4:0] of the status word: user 5'h10, system-user 5'h1F, privileged 5'h13, trap 5'h17, extension 5'h1B, interrupt 5'h12. Bit 7 of the status word is the interrupt-disable bit. Bank numbers are: user and system-user share bank 0, privileged uses bank 1, trap bank 2, extension bank 3 and interrupt bank 4. Request bit 0 is a data trap, bit 1 an instruction trap, bit 2 a privileged exception and bit 3 an interrupt.

Top module: `mode_bank_exc_entry`

## Requirements
- R1: During and after synchronous reset, `asr_o` is 32'h0000_0013 (privileged mode), `pc_o`, `r29_o`, `r30_o`, `bsr_o` are zero, `done`, `ack` and `mode_err` are low, and every bank holds zeros.
- R2: When several request bits are set together, the one taken is chosen in this order: data trap (bit 0), then instruction trap (bit 1), then privileged (bit 2), then interrupt (bit 3).
- R3: A data trap enters trap mode (5'h17) with vector offset 0x10. An instruction trap enters trap mode with offset 0x0C. A privileged exception enters privileged mode (5'h13) with offset 0x08. An interrupt enters interrupt mode (5'h12) with offset 0x18.
- R4: When `hivec_en` is high at acceptance, the committed PC is 32'hFFFF_0000 plus the offset. When it is low, the committed PC is the offset alone.
- R5: At commit, `bsr_o` holds the status word sampled at acceptance. `asr_o` holds that word with bits [4:0] replaced by the new mode code and bit 7 set, and all other bits unchanged.
- R6: At commit, `r30_o` holds the PC sampled at acceptance, and `pc_o` holds the vector address.
- R7: If the old and new modes differ, the sampled r29, r30 and saved-status values are written into the old mode's bank. The new mode's bank is then presented on `r29_o`, `r30_o` and `bsr_o` one cycle before commit. `r29_o` keeps the restored value through commit.
- R8: If the new mode equals the current mode, no bank is written or read. The sampled r29, r30 and saved-status values appear on the outputs in the restore cycle, and `r29_o` keeps the sampled r29 through commit.
- R9: If the sampled mode field is not one of the six legal codes, `mode_err` goes high one cycle after acceptance and stays high until reset. No `done` pulse follows, and the outputs and banks are left unchanged.
- R10: `ack` is high only while the unit is idle, `req_valid` is high and at least one request bit is set. It is low for the rest of an entry. `done` is a single-cycle pulse that appears three clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_kind | input | 4 | Request bits: 0 data trap, 1 instruction trap, 2 privileged, 3 interrupt |
| hivec_en | input | 1 | Relocate vectors to 32'hFFFF_0000 |
| ack | output | 1 | Request accepted on this edge |
| asr_i | input | 32 | Live status word |
| pc_i | input | 32 | Live PC (return address) |
| r29_i | input | 32 | Live r29 |
| r30_i | input | 32 | Live r30 |
| bsr_i | input | 32 | Live saved-status word |
| asr_o | output | 32 | Status word after entry |
| pc_o | output | 32 | PC after entry (vector) |
| r29_o | output | 32 | r29 after bank switch |
| r30_o | output | 32 | r30: restored value, then return address |
| bsr_o | output | 32 | Saved status: restored value, then pre-entry status |
| done | output | 1 | One-cycle pulse when the PC is redirected |
| mode_err | output | 1 | Sticky illegal-mode flag |

## Verification
Every result has a fixed cycle, counted from the edge that accepts the request. `ack` falls at that edge. `mode_err` rises on the next edge. The restored bank values appear after the second edge. `done` and the committed status, PC, r29, r30 and saved-status values appear after the third edge, and `done` drops after the fourth. The bench drives inputs at falling edges and counts rising edges from acceptance. It samples each result at the falling edge that follows the rising edge where that result is due. A reference copy of the five banks, updated by the save rule, supplies the expected restored values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int DATA_W     = 32;
    localparam int MODE_W     = 5;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int NUM_KINDS  = 4;
    localparam int OFF_W      = 8;
    localparam int IBIT       = 7;
    localparam logic [DATA_W-1:0] MODE_MASK = {{(DATA_W-MODE_W){1'b0}}, {MODE_W{1'b1}}};

    typedef enum logic [MODE_W-1:0] {
        M_USER = 5'h10,
        M_SUSR = 5'h1F,
        M_PRIV = 5'h13,
        M_TRAP = 5'h17,
        M_EXTN = 5'h1B,
        M_INTR = 5'h12
    } mode_e;

    // Encoding equals the request bit index; lower index wins.
    typedef enum logic [1:0] {
        K_DTRAP = 2'd0,
        K_ITRAP = 2'd1,
        K_PRIV  = 2'd2,
        K_INTR  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_LOAD,
        ST_COMMIT
    } state_e;

    typedef struct packed {
        logic                  legal;
        logic [BANK_IDX_W-1:0] idx;
    } bank_sel_t;

    typedef struct packed {
        mode_e            mode;
        logic [OFF_W-1:0] off;
    } target_t;

    typedef struct packed {
        logic [DATA_W-1:0] r29;
        logic [DATA_W-1:0] r30;
        logic [DATA_W-1:0] bsr;
    } bank_t;

    function automatic bank_sel_t bank_of(input logic [MODE_W-1:0] m);
        bank_sel_t s;
        s = '0;
        case (m)
            M_USER, M_SUSR: s = '{legal: 1'b1, idx: BANK_IDX_W'(0)};
            M_PRIV:         s = '{legal: 1'b1, idx: BANK_IDX_W'(1)};
            M_TRAP:         s = '{legal: 1'b1, idx: BANK_IDX_W'(2)};
            M_EXTN:         s = '{legal: 1'b1, idx: BANK_IDX_W'(3)};
            M_INTR:         s = '{legal: 1'b1, idx: BANK_IDX_W'(4)};
            default:        s = '0;
        endcase
        return s;
    endfunction

    function automatic target_t target_of(input kind_e k);
        target_t t;
        case (k)
            K_DTRAP: t = '{mode: M_TRAP, off: 8'h10};
            K_ITRAP: t = '{mode: M_TRAP, off: 8'h0C};
            K_PRIV:  t = '{mode: M_PRIV, off: 8'h08};
            default: t = '{mode: M_INTR, off: 8'h18};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/exc_select.sv
module exc_select
    import exc_entry_pkg::*;
(
    input  logic [NUM_KINDS-1:0] req_kind,
    output logic                 any,
    output kind_e                kind
);
    always_comb begin
        kind = K_INTR;
        for (int i = NUM_KINDS - 1; i >= 0; i--) begin
            if (req_kind[i]) kind = kind_e'(i[1:0]);
        end
    end

    assign any = |req_kind;

endmodule

// File: rtl/exc_bank_store.sv
module exc_bank_store
    import exc_entry_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [BANK_IDX_W-1:0] widx,
    input  bank_t                 wdata,
    input  logic [BANK_IDX_W-1:0] ridx,
    output bank_t                 rdata
);
    bank_t slot [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (widx == BANK_IDX_W'(g))) begin
                q <= wdata;
            end
        end
        assign slot[g] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (ridx == BANK_IDX_W'(i)) rdata = slot[i];
        end
    end

endmodule

// File: rtl/mode_bank_exc_entry.sv
module mode_bank_exc_entry
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] HIVEC_BASE = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_kind,
    input  logic        hivec_en,
    output logic        ack,
    input  logic [31:0] asr_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] r29_i,
    input  logic [31:0] r30_i,
    input  logic [31:0] bsr_i,
    output logic [31:0] asr_o,
    output logic [31:0] pc_o,
    output logic [31:0] r29_o,
    output logic [31:0] r30_o,
    output logic [31:0] bsr_o,
    output logic        done,
    output logic        mode_err
);
    state_e      state;
    kind_e       kind_sel, kind_q;
    logic        any_req;
    logic        hivec_q;
    logic [31:0] asr_q, pc_q;
    bank_t       live_q, bank_rd, bank_wr;
    bank_sel_t   old_sel, new_sel;
    target_t     tgt;
    logic        same_mode, bank_we;
    logic [31:0] vector, asr_new;

    exc_select u_select (
        .req_kind (req_kind),
        .any      (any_req),
        .kind     (kind_sel)
    );

    assign ack = (state == ST_IDLE) && req_valid && any_req;

    assign tgt       = target_of(kind_q);
    assign old_sel   = bank_of(asr_q[MODE_W-1:0]);
    assign new_sel   = bank_of(tgt.mode);
    assign same_mode = (asr_q[MODE_W-1:0] == tgt.mode);
    assign bank_we   = (state == ST_SAVE) && old_sel.legal && !same_mode;
    assign bank_wr   = live_q;
    assign vector    = (hivec_q ? HIVEC_BASE : 32'h0) + {{(DATA_W-OFF_W){1'b0}}, tgt.off};
    assign asr_new   = (asr_q & ~MODE_MASK) | {{(DATA_W-MODE_W){1'b0}}, tgt.mode}
                     | (32'h1 << IBIT);

    exc_bank_store u_banks (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .widx  (old_sel.idx),
        .wdata (bank_wr),
        .ridx  (new_sel.idx),
        .rdata (bank_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind_q   <= K_INTR;
            hivec_q  <= 1'b0;
            asr_q    <= '0;
            pc_q     <= '0;
            live_q   <= '0;
            asr_o    <= {{(DATA_W-MODE_W){1'b0}}, M_PRIV};
            pc_o     <= '0;
            r29_o    <= '0;
            r30_o    <= '0;
            bsr_o    <= '0;
            done     <= 1'b0;
            mode_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ack) begin
                        kind_q  <= kind_sel;
                        hivec_q <= hivec_en;
                        asr_q   <= asr_i;
                        pc_q    <= pc_i;
                        live_q  <= '{r29: r29_i, r30: r30_i, bsr: bsr_i};
                        state   <= ST_SAVE;
                    end
                end
                ST_SAVE: begin
                    if (!old_sel.legal) begin
                        mode_err <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (same_mode) begin
                        r29_o <= live_q.r29;
                        r30_o <= live_q.r30;
                        bsr_o <= live_q.bsr;
                    end else begin
                        r29_o <= bank_rd.r29;
                        r30_o <= bank_rd.r30;
                        bsr_o <= bank_rd.bsr;
                    end
                    state <= ST_COMMIT;
                end
                default: begin
                    bsr_o <= asr_q;
                    asr_o <= asr_new;
                    r30_o <= pc_q;
                    pc_o  <= vector;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_ack_then_busy: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);
    a_r6_pc_moves_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_o) |-> done);
    a_r5_irq_masked: assert property (@(posedge clk) disable iff (rst)
        done |-> asr_o[IBIT]);
    a_r3_legal_target: assert property (@(posedge clk) disable iff (rst)
        done |-> bank_of(asr_o[MODE_W-1:0]).legal);

endmodule

// File: tb/mode_bank_exc_entry_bench.sv
module mode_bank_exc_entry_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = 4'h0;
    logic        hivec_en = 1'b0;
    logic        ack;
    logic [31:0] asr_i = '0, pc_i = '0, r29_i = '0, r30_i = '0, bsr_i = '0;
    logic [31:0] asr_o, pc_o, r29_o, r30_o, bsr_o;
    logic        done, mode_err;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m29 [5];
    logic [31:0] m30 [5];
    logic [31:0] mbsr [5];

    always #10 clk = ~clk;

    mode_bank_exc_entry u_mode_bank_exc_entry (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .hivec_en(hivec_en), .ack(ack), .asr_i(asr_i), .pc_i(pc_i),
        .r29_i(r29_i), .r30_i(r30_i), .bsr_i(bsr_i), .asr_o(asr_o),
        .pc_o(pc_o), .r29_o(r29_o), .r30_o(r30_o), .bsr_o(bsr_o),
        .done(done), .mode_err(mode_err)
    );

    task automatic chk(input string what, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int bidx(input logic [4:0] m);
        case (m)
            5'h10, 5'h1F: return 0;
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            default: return 4;
        endcase
    endfunction

    // Legal entry; exp_mode/exp_off computed by hand from R2/R3.
    task automatic entry(input string name, input string tag, input logic [3:0] kind,
                         input logic [31:0] asr, input logic [31:0] pc,
                         input logic [31:0] a29, input logic [31:0] a30,
                         input logic [31:0] absr, input logic hv,
                         input logic [4:0] exp_mode, input logic [31:0] exp_off);
        logic [31:0] e29, e30, ebsr, evec, easr;
        int ob, nb;
        ob = bidx(asr[4:0]);
        nb = bidx(exp_mode);
        if (asr[4:0] != exp_mode) begin
            m29[ob] = a29; m30[ob] = a30; mbsr[ob] = absr;
            e29 = m29[nb]; e30 = m30[nb]; ebsr = mbsr[nb];
        end else begin
            e29 = a29; e30 = a30; ebsr = absr;
        end
        evec = (hv ? 32'hFFFF_0000 : 32'h0) + exp_off;
        easr = (asr & ~32'h1F) | {27'b0, exp_mode} | 32'h80;
        @(negedge clk);
        asr_i = asr; pc_i = pc; r29_i = a29; r30_i = a30; bsr_i = absr;
        hivec_en = hv; req_kind = kind; req_valid = 1'b1;
        #1 chk({name, " ack idle"}, "R10", 32'(ack), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk({name, " ack busy"}, "R10", 32'(ack), 32'd0);
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk({name, " restore r29"}, "R7/R8", r29_o, e29);
        chk({name, " restore r30"}, "R7/R8", r30_o, e30);
        chk({name, " restore bsr"}, "R7/R8", bsr_o, ebsr);
        chk({name, " done early"}, "R10", 32'(done), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk({name, " done"}, "R10", 32'(done), 32'd1);
        chk({name, " vector"}, tag, pc_o, evec);
        chk({name, " status"}, "R5", asr_o, easr);
        chk({name, " saved status"}, "R5", bsr_o, asr);
        chk({name, " return addr"}, "R6", r30_o, pc);
        chk({name, " r29 final"}, "R7", r29_o, e29);
        @(posedge clk);
        @(negedge clk);
        chk({name, " done drop"}, "R10", 32'(done), 32'd0);
    endtask

    task automatic illegal_mode();
        logic [31:0] p_asr, p_pc, p_29;
        p_asr = asr_o; p_pc = pc_o; p_29 = r29_o;
        @(negedge clk);
        asr_i = 32'h0000_0005; pc_i = 32'h7000; r29_i = 32'hBAD0_0029;
        r30_i = 32'hBAD0_0030; bsr_i = 32'hBAD0_0B5B;
        req_kind = 4'b0100; req_valid = 1'b1;
        #1 chk("illegal ack", "R9", 32'(ack), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("illegal err", "R9", 32'(mode_err), 32'd1);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("illegal no done", "R9", 32'(done), 32'd0);
        end
        chk("illegal pc kept", "R9", pc_o, p_pc);
        chk("illegal asr kept", "R9", asr_o, p_asr);
        chk("illegal r29 kept", "R9", r29_o, p_29);
    endtask

    task automatic reset_state();
        @(negedge clk);
        chk("reset asr", "R1", asr_o, 32'h0000_0013);
        chk("reset pc", "R1", pc_o, 32'h0);
        chk("reset r29", "R1", r29_o, 32'h0);
        chk("reset done", "R1", 32'(done), 32'd0);
        chk("reset err", "R1", 32'(mode_err), 32'd0);
        req_valid = 1'b1; req_kind = 4'h0;
        #1 chk("no kind no ack", "R10", 32'(ack), 32'd0);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 5000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            m29[i] = '0; m30[i] = '0; mbsr[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reset_state();
        entry("all four", "R2", 4'b1111, 32'h0000_0013, 32'h1000,
              32'hA1, 32'hA2, 32'hA3, 1'b0, 5'h17, 32'h10);
        entry("itrap over priv", "R2", 4'b0110, 32'h0000_0310, 32'h2000,
              32'hB1, 32'hB2, 32'hB3, 1'b0, 5'h17, 32'h0C);
        entry("priv over intr hi", "R4", 4'b1100, 32'h0000_0017, 32'h3000,
              32'hC1, 32'hC2, 32'hC3, 1'b1, 5'h13, 32'h08);
        entry("intr hi", "R4", 4'b1000, 32'h0000_001F, 32'h4000,
              32'hD1, 32'hD2, 32'hD3, 1'b1, 5'h12, 32'h18);
        entry("same mode", "R3", 4'b0001, 32'h0000_0017, 32'h5000,
              32'hE1, 32'hE2, 32'hE3, 1'b0, 5'h17, 32'h10);
        entry("trap from intr", "R3", 4'b0010, 32'h0000_0012, 32'h6000,
              32'hF1, 32'hF2, 32'hF3, 1'b0, 5'h17, 32'h0C);
        entry("intr from priv", "R3", 4'b1000, 32'h0000_0013, 32'h6800,
              32'h91, 32'h92, 32'h93, 1'b0, 5'h12, 32'h18);
        entry("priv from extn", "R3", 4'b0100, 32'h0000_001B, 32'h6C00,
              32'h81, 32'h82, 32'h83, 1'b0, 5'h13, 32'h08);
        illegal_mode();
        entry("after error", "R3", 4'b0100, 32'h0000_0017, 32'h8000,
              32'h71, 32'h72, 32'h73, 1'b0, 5'h13, 32'h08);
        chk("err still set", "R9", 32'(mode_err), 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule